// File: doc/BRIEF.md
# MDIO Single-Command Management Engine

This block is a management-bus master for Ethernet PHYs. It carries out one clause-22 transaction each time the host issues a command through a small register window. To write a PHY register, the host first loads the value into the data register. It then writes a command word that sets the busy flag, one opcode bit, the PHY address and the register number. The engine serialises the frame on the management clock and data lines, then clears busy.

For a read, the engine releases the data line at the turnaround. It shifts in the sixteen bits the PHY returns and places them in the upper half of the data register. A separate status register records whether the PHY failed to pull the second turnaround bit low.

The management clock comes from the system clock through an even divider. It runs continuously. The data line is updated on the falling edge of the management clock and sampled on the rising edge. The host polls busy before and after each transaction.

Top module: `mdio_cmd_engine`

## Requirements
- R1: While reset is asserted, the command, data and status registers read as zero, `mdio_oe` is low and `mdc` is low.
- R2: A write to the command register (offset 0) is accepted only when all three of these hold: busy is clear, bit 20 is set, and exactly one of bit 17 (read) and bit 16 (write) is set. An accepted command runs one frame. Command bit 20 then reads 1 until that frame ends and reads 0 afterwards.
- R3: Every frame is sent MSB first in this order: 32 ones, the start code 01, and the opcode (10 for a read, 01 for a write). The opcode is followed by the 5-bit PHY address from command bits 12:8 and then the 5-bit register number from command bits 4:0.
- R4: A write frame continues with turnaround 10, followed by bits 15:0 of the data register (offset 1), MSB first.
- R5: A read frame holds `mdio_oe` low from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround appear in data register bits 31:16, with the first sampled bit in bit 31.
- R6: Status register (offset 2) bit 0 becomes 1 when a read samples the second turnaround bit high, and becomes 0 when a read samples it low. Write frames leave it unchanged.
- R7: While busy is set, writes to the command register and to the data register are ignored. The running frame and the command fields read back stay as they were.
- R8: A command write with bit 20 clear, or with both or neither of bits 17 and 16 set, starts no frame and leaves busy clear.
- R9: `mdc` has a period of `CLK_DIV` system clocks with equal high and low times. `mdio_out` changes only on the system clock edge at which `mdc` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; `bus_rdata` is zero when low |
| bus_addr | input | 2 | Register offset: 0 command, 1 data, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Sampled management data line |
| mdio_out | output | 1 | Driven management data value |
| mdio_oe | output | 1 | Output enable for the management data line |

## Verification
On every cycle, the assertions check the following:
- the management clock toggles only when the divider count ends;
- the data output moves only on a falling management-clock tick;
- the line is released during the turnaround and data phase of a read;
- busy clears only when the sequencer reports completion;
- a write while busy leaves the command fields and the data register untouched;
- a command without the busy bit starts nothing;
- the status bit changes only on a completed read.

Only the bench scenarios can show the rest, because it depends on the bit stream and the PHY's replies. This covers:
- the exact order and content of the frame bits;
- read data reaching the upper half of the data register;
- the invalid-turnaround flag being set and then cleared;
- the management-clock period.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    // command word fields; the host software decodes these positions
    localparam int BUSY_BIT = 20;
    localparam int RD_BIT   = 17;
    localparam int WR_BIT   = 16;
    localparam int PHY_LSB  = 8;
    localparam int REG_LSB  = 0;
    localparam int FLD_W    = 5;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] phy;
        logic [FLD_W-1:0] regn;
        logic             rd;
        logic             wr;
    } cmd_fields_t;

endpackage

// File: rtl/mdio_mdc_div.sv
// Free-running even divider producing the management clock and
// one-cycle tick pulses that mark the clk edge at which it rises or falls.
module mdio_mdc_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;
    logic terminal;

    assign terminal = (div_q.cnt == CW'(HALF - 1));

    always_comb begin
        div_d = div_q;
        if (terminal) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mdc       = div_q.mdc;
    assign rise_tick = terminal && !div_q.mdc;
    assign fall_tick = terminal &&  div_q.mdc;

    // R9
    mdc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q.mdc) |-> $past(terminal));

    // R9
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= CW'(HALF - 1));

endmodule

// File: rtl/mdio_frame_seq.sv
// Serialises one clause-22 frame and captures the read reply.
module mdio_frame_seq
    import mdio_cmd_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             start,
    input  logic             is_rd,
    input  logic [FLD_W-1:0] phy,
    input  logic [FLD_W-1:0] regn,
    input  logic [15:0]      wval,
    input  logic             mdio_in,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             rd_invalid,
    output logic             mdio_out,
    output logic             mdio_oe
);
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int CW        = $clog2(FRAME_LEN);
    localparam int LAST      = FRAME_LEN - 1;
    localparam int TA1       = PRE_LEN + 14;
    localparam int TA2       = PRE_LEN + 15;
    localparam int DAT0      = PRE_LEN + 16;

    typedef struct packed {
        seq_state_e           state;
        logic                 is_rd;
        logic [CW-1:0]        cnt;
        logic [FRAME_LEN-1:0] tx;
        logic [15:0]          rx;
        logic                 bad;
        logic                 out;
        logic                 oe;
        logic                 done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CW-1:0] cnt_nxt;

    assign cnt_nxt = seq_q.cnt + CW'(1);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.state = SEQ_WAIT;
                    seq_d.is_rd = is_rd;
                    seq_d.bad   = 1'b0;
                    seq_d.rx    = '0;
                    seq_d.tx    = {{PRE_LEN{1'b1}}, 2'b01,
                                   is_rd ? 2'b10 : 2'b01,
                                   phy, regn,
                                   is_rd ? 2'b11 : 2'b10,
                                   is_rd ? 16'hFFFF : wval};
                end
            end
            SEQ_WAIT: begin
                if (fall_tick) begin
                    seq_d.state = SEQ_RUN;
                    seq_d.cnt   = '0;
                    seq_d.out   = seq_q.tx[LAST];
                    seq_d.tx    = seq_q.tx << 1;
                    seq_d.oe    = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (fall_tick) begin
                    if (seq_q.cnt == CW'(LAST)) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.oe    = 1'b0;
                        seq_d.out   = 1'b1;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.cnt = cnt_nxt;
                        seq_d.out = seq_q.tx[LAST];
                        seq_d.tx  = seq_q.tx << 1;
                        seq_d.oe  = !(seq_q.is_rd && (cnt_nxt >= CW'(TA1)));
                    end
                end else if (rise_tick && seq_q.is_rd) begin
                    if (seq_q.cnt == CW'(TA2)) begin
                        seq_d.bad = mdio_in;
                    end else if (seq_q.cnt >= CW'(DAT0)) begin
                        seq_d.rx = {seq_q.rx[14:0], mdio_in};
                    end
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SEQ_IDLE;
            seq_q.out   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done       = seq_q.done;
    assign rdata      = seq_q.rx;
    assign rd_invalid = seq_q.bad;
    assign mdio_out   = seq_q.out;
    assign mdio_oe    = seq_q.oe;

    // R9
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(mdio_out));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SEQ_RUN && seq_q.is_rd && seq_q.cnt >= CW'(TA1)) |-> !mdio_oe);

    // R2
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fall_tick));

endmodule

// File: rtl/mdio_cmd_engine.sv
// Register window plus management clock divider and frame sequencer.
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe
);
    typedef struct packed {
        logic        busy;
        cmd_fields_t cmd;
        logic [15:0] wval;
        logic [15:0] rval;
        logic        invalid;
    } regs_t;

    regs_t regs_d, regs_q;

    logic        rise_tick, fall_tick;
    logic        accept;
    logic        seq_done, seq_bad;
    logic [15:0] seq_rdata;
    logic        unused_bits;

    assign unused_bits = ^{bus_wdata[31:21], bus_wdata[19:18],
                           bus_wdata[15:13], bus_wdata[7:5]};

    assign accept = bus_wr && (bus_addr == OFS_CMD) && !regs_q.busy &&
                    bus_wdata[BUSY_BIT] && (bus_wdata[RD_BIT] ^ bus_wdata[WR_BIT]);

    always_comb begin
        regs_d = regs_q;
        if (accept) begin
            regs_d.busy     = 1'b1;
            regs_d.cmd.rd   = bus_wdata[RD_BIT];
            regs_d.cmd.wr   = bus_wdata[WR_BIT];
            regs_d.cmd.phy  = bus_wdata[PHY_LSB +: FLD_W];
            regs_d.cmd.regn = bus_wdata[REG_LSB +: FLD_W];
        end
        if (bus_wr && (bus_addr == OFS_DATA) && !regs_q.busy) begin
            regs_d.wval = bus_wdata[15:0];
        end
        if (seq_done) begin
            regs_d.busy = 1'b0;
            if (regs_q.cmd.rd) begin
                regs_d.rval    = seq_rdata;
                regs_d.invalid = seq_bad;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_CMD: begin
                    bus_rdata[BUSY_BIT]              = regs_q.busy;
                    bus_rdata[RD_BIT]                = regs_q.cmd.rd;
                    bus_rdata[WR_BIT]                = regs_q.cmd.wr;
                    bus_rdata[PHY_LSB +: FLD_W]      = regs_q.cmd.phy;
                    bus_rdata[REG_LSB +: FLD_W]      = regs_q.cmd.regn;
                end
                OFS_DATA: bus_rdata = {regs_q.rval, regs_q.wval};
                OFS_STAT: bus_rdata[0] = regs_q.invalid;
                default:  bus_rdata = '0;
            endcase
        end
    end

    mdio_mdc_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .start      (accept),
        .is_rd      (bus_wdata[RD_BIT]),
        .phy        (bus_wdata[PHY_LSB +: FLD_W]),
        .regn       (bus_wdata[REG_LSB +: FLD_W]),
        .wval       (regs_q.wval),
        .mdio_in    (mdio_in),
        .done       (seq_done),
        .rdata      (seq_rdata),
        .rd_invalid (seq_bad),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    // R2
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.busy) |-> $past(seq_done));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.busy && bus_wr) |=> ($stable(regs_q.cmd) && $stable(regs_q.wval)));

    // R8
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && !regs_q.busy && !bus_wdata[BUSY_BIT]) |=> !regs_q.busy);

    // R6
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> $stable(regs_q.invalid));

endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_in = 1'b1;
    logic        mdio_out;
    logic        mdio_oe;

    always #10 clk = ~clk;

    mdio_cmd_engine #(.CLK_DIV(4), .PRE_LEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // PHY model: records frame bits on rising mdc, answers reads on falling mdc
    logic [63:0] cap = '0;
    int          pos = 0;
    bit          active = 0;
    bit          model_rd = 0;
    bit          oe_bad = 0;
    int          frames = 0;
    logic [15:0] resp = '0;
    bit          resp_ta_ok = 1;

    always @(posedge mdc) begin
        if (!active && mdio_oe) begin
            active = 1; pos = 0; cap = '0; oe_bad = 0; model_rd = 0;
        end
        if (active) begin
            cap[63-pos] = mdio_out;
            if (pos == 35) model_rd = (cap[63-34] == 1'b1) && (cap[63-35] == 1'b0);
            if (model_rd && pos >= 46 && mdio_oe) oe_bad = 1;
            pos++;
            if (pos == 64) begin
                active = 0;
                frames++;
            end
        end
    end

    always @(negedge mdc) begin
        if (active && model_rd && pos == 47) mdio_in = resp_ta_ok ? 1'b0 : 1'b1;
        else if (active && model_rd && pos >= 48 && pos <= 63) mdio_in = resp[63-pos];
        else mdio_in = 1'b1;
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] r;
        ok = 0;
        for (int k = 0; k < 3000; k++) begin
            bus_read(2'd0, r);
            if (!r[20]) begin
                ok = 1;
                break;
            end
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit busy, input bit rd, input bit wr,
                                           input logic [4:0] phy, input logic [4:0] rg);
        logic [31:0] c;
        c = '0;
        c[20] = busy; c[17] = rd; c[16] = wr;
        c[12:8] = phy; c[4:0] = rg;
        return c;
    endfunction

    function automatic logic [63:0] mk_frame(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] v);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, v};
    endfunction

    // {rd, phy[4:0], reg[4:0], value[15:0], turnaround_ok}
    localparam logic [27:0] VEC [0:5] = '{
        {1'b0, 5'h01, 5'h00, 16'h1234, 1'b1},
        {1'b1, 5'h03, 5'h02, 16'hBEEF, 1'b1},
        {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b1},
        {1'b1, 5'h00, 5'h00, 16'h0001, 1'b1},
        {1'b1, 5'h10, 5'h05, 16'hA5A5, 1'b0},
        {1'b1, 5'h15, 5'h0A, 16'h8001, 1'b1}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] exp;
        bit          ok;
        int          f0;
        time         t0, t1, t2;

        // R1: reset state
        repeat (3) @(negedge clk);
        bus_read(2'd0, r); check(r == 32'h0, "R1", "cmd reg in reset", {32'h0, r}, 64'h0);
        bus_read(2'd1, r); check(r == 32'h0, "R1", "data reg in reset", {32'h0, r}, 64'h0);
        bus_read(2'd2, r); check(r == 32'h0, "R1", "status reg in reset", {32'h0, r}, 64'h0);
        check(mdio_oe == 1'b0, "R1", "mdio_oe in reset", {63'h0, mdio_oe}, 64'h0);
        check(mdc == 1'b0, "R1", "mdc in reset", {63'h0, mdc}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table-driven transactions: R2 R3 R4 R5 R6
        for (int i = 0; i < 6; i++) begin
            logic [27:0] v;
            bit          rd;
            logic [4:0]  phy, rg;
            logic [15:0] val;
            bit          ta;
            v = VEC[i];
            rd = v[27]; phy = v[26:22]; rg = v[21:17]; val = v[16:1]; ta = v[0];
            resp = val; resp_ta_ok = ta;
            f0 = frames;
            if (!rd) bus_write(2'd1, {16'h0, val});
            bus_write(2'd0, mk_cmd(1, rd, !rd, phy, rg));
            bus_read(2'd0, r);
            check(r[20] == 1'b1, "R2", "busy after issue", {63'h0, r[20]}, 64'h1);
            wait_idle(ok);
            check(ok, "R2", "busy clears", {63'h0, ok}, 64'h1);
            check(frames == f0 + 1, "R2", "one frame per command", 64'(frames - f0), 64'h1);
            exp = mk_frame(rd, phy, rg, val);
            check(cap[63:18] == exp[63:18], "R3", "frame header", {18'h0, cap[63:18]},
                  {18'h0, exp[63:18]});
            if (!rd) begin
                check(cap[17:0] == exp[17:0], "R4", "turnaround and write data",
                      {46'h0, cap[17:0]}, {46'h0, exp[17:0]});
            end else begin
                check(!oe_bad, "R5", "line released in read", {63'h0, oe_bad}, 64'h0);
                bus_read(2'd2, r);
                check(r[0] == !ta, "R6", "invalid flag", {63'h0, r[0]}, {63'h0, !ta});
                if (ta) begin
                    bus_read(2'd1, r);
                    check(r[31:16] == val, "R5", "read data upper half",
                          {48'h0, r[31:16]}, {48'h0, val});
                end
            end
        end

        // R6: invalid read, then a write frame leaves the flag set
        resp_ta_ok = 0; resp = 16'h0;
        bus_write(2'd0, mk_cmd(1, 1, 0, 5'h02, 5'h01));
        wait_idle(ok);
        bus_read(2'd2, r);
        check(r[0] == 1'b1, "R6", "flag set by bad turnaround", {63'h0, r[0]}, 64'h1);
        resp_ta_ok = 1;
        bus_write(2'd1, 32'h0000_5555);
        bus_write(2'd0, mk_cmd(1, 0, 1, 5'h02, 5'h01));
        wait_idle(ok);
        bus_read(2'd2, r);
        check(r[0] == 1'b1, "R6", "write frame keeps flag", {63'h0, r[0]}, 64'h1);

        // R8: malformed commands start nothing
        f0 = frames;
        bus_write(2'd0, mk_cmd(0, 1, 0, 5'h03, 5'h01));
        bus_read(2'd0, r);
        check(r[20] == 1'b0, "R8", "no busy bit", {63'h0, r[20]}, 64'h0);
        bus_write(2'd0, mk_cmd(1, 1, 1, 5'h03, 5'h01));
        bus_read(2'd0, r);
        check(r[20] == 1'b0, "R8", "both op bits", {63'h0, r[20]}, 64'h0);
        bus_write(2'd0, mk_cmd(1, 0, 0, 5'h03, 5'h01));
        bus_read(2'd0, r);
        check(r[20] == 1'b0, "R8", "no op bit", {63'h0, r[20]}, 64'h0);
        repeat (400) @(negedge clk);
        check(frames == f0, "R8", "no frame emitted", 64'(frames - f0), 64'h0);

        // R7: writes while busy are ignored
        f0 = frames;
        bus_write(2'd1, 32'h0000_0F0F);
        bus_write(2'd0, mk_cmd(1, 0, 1, 5'h02, 5'h03));
        repeat (5) @(negedge clk);
        bus_write(2'd1, 32'h0000_AAAA);
        bus_write(2'd0, mk_cmd(1, 1, 0, 5'h07, 5'h09));
        bus_read(2'd0, r);
        check(r[12:8] == 5'h02 && r[4:0] == 5'h03 && r[16] && !r[17] && r[20], "R7",
              "command fields held", {32'h0, r}, {32'h0, mk_cmd(1, 0, 1, 5'h02, 5'h03)});
        wait_idle(ok);
        check(frames == f0 + 1, "R7", "single frame", 64'(frames - f0), 64'h1);
        exp = mk_frame(0, 5'h02, 5'h03, 16'h0F0F);
        check(cap == exp, "R7", "frame of first command", cap, exp);
        bus_read(2'd1, r);
        check(r[15:0] == 16'h0F0F, "R7", "data low half held", {48'h0, r[15:0]}, 64'h0F0F);

        // R9: mdc period and duty
        @(posedge mdc); t0 = $time;
        @(negedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        check((t2 - t0) == 80, "R9", "mdc period ns", 64'(t2 - t0), 64'd80);
        check((t1 - t0) == 40, "R9", "mdc high time ns", 64'(t1 - t0), 64'd40);

        summary();
        $finish;
    end

endmodule